// File: doc/BRIEF.md
# SD card clock divider control

This block derives the clock for an SD or MMC card from the host reference clock. Software picks a power-of-two ratio through a one-hot code held in a 16-bit clock-control word. It starts or stops the card clock with an enable bit in that word, and it must also place the run value 0x0100 in a separate run-gate register before any clock reaches the card. A one-bit mode register chooses between the divided path and a direct path, which passes the host clock straight through. With a 24 MHz reference, the divided path covers ratios from 4 up to 512, so the slowest setting is 46875 Hz.

Settings never take effect in the middle of a card clock phase. A new combination of enable, ratio and mode is adopted only at the end of a low phase of the divided clock. Because of this, every high and low phase that reaches the card has the full length of the setting in force, and a stop request lets the current high phase finish. A busy output stays high while a written setting is still waiting for that boundary. Software starts the clock by setting the enable bit and then writing the run-gate register, and it stops the clock in the reverse order.

Top module: `sdclk_ctrl`

## Requirements
- R1: After reset the card clock is low and busy is low. The clock-control word reads 0x0040 (disabled, slowest ratio), the mode register reads 1 and the run-gate register reads 0.
- R2: Address 0 is the 16-bit clock-control word: bit 8 is the enable and bits 6..0 are the ratio code. Address 1 is the mode register in bit 0 (1 divided, 0 direct). Address 2 is the 16-bit run-gate register. Each reads back the last value written, and address 3 reads zero.
- R3: In divided mode with the clock running, a code with only bit k set (k from 0 to 6) gives a card clock whose high and low phases each last 2^(k+2) host cycles, a ratio of 2^(k+3).
- R4: A code with none of bits 6..0 set gives a ratio of 4 (two cycles high, two low). Bit 7 of the word has no effect on the ratio.
- R5: When several code bits are set, the lowest set bit alone decides the ratio.
- R6: The card clock runs only while the enable bit is 1 and the run-gate register holds exactly 0x0100. Any other combination holds it low once applied.
- R7: A setting change is adopted only where a low phase of the divided clock ends. Every high phase has the full length of its setting, and a stop never shortens the high phase in progress.
- R8: Busy goes high in the cycle after a write that changes the effective enable, ratio or mode. It clears when the new setting is adopted, at most two half periods of the old setting after the write. A write that leaves those unchanged keeps busy low.
- R9: In direct mode the running card clock equals the host clock: high during the host high phase and low during its low phase. It stays low when stopped.
- R10: Clearing the enable bit stops the clock and leaves the code as written. Setting the enable bit again resumes the same ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, sampled on the rising clock edge |
| wr_addr | input | 2 | Register selected for the write |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Register selected for readback |
| rd_data | output | 16 | Readback data, combinational from rd_addr |
| card_clk | output | 1 | Clock delivered to the card |
| busy | output | 1 | High while a written setting awaits adoption |

## Verification
A write lands at the rising edge that samples wr_en, so readback and the rise of busy are due one cycle later, and the bench samples them one time unit after that edge. Adoption falls on the next end of a low phase, up to two old half periods away. The bench therefore polls busy after every write, bounds the wait, and only then arms the scoreboard, which measures whole periods starting from a rising card clock edge sampled at mid-cycle. Direct-mode output is sampled inside the host high and low phases, starting one cycle after adoption, since its gate is refreshed on the host clock's falling edge.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

   // register selects on the write and read ports
   typedef enum logic [1:0] {
      SEL_CTL  = 2'd0,
      SEL_MODE = 2'd1,
      SEL_GATE = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   // position of the card clock enable in the clock-control word
   localparam int unsigned EN_BIT   = 8;
   // value the run-gate register must hold for the clock to run
   localparam int unsigned RUN_WORD = 32'h0100;

endpackage

// File: rtl/sdclk_regs.sv
module sdclk_regs
   import sdclk_pkg::*;
#(
   parameter int unsigned REG_W  = 16,
   parameter int unsigned CODE_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic [1:0]        rd_addr,
   output logic [REG_W-1:0]  rd_data,
   output logic              ctl_en,
   output logic [CODE_W-1:0] ctl_code,
   output logic              mode_div,
   output logic              gate_ok
);

   localparam logic [REG_W-1:0] CTL_RST  = REG_W'(1) << (CODE_W - 1);
   localparam logic [REG_W-1:0] GATE_RUN = REG_W'(RUN_WORD);

   logic [REG_W-1:0] ctl_q;
   logic [REG_W-1:0] gate_q;
   logic             mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q  <= CTL_RST;
         gate_q <= '0;
         mode_q <= 1'b1;
      end else if (wr_en) begin
         unique case (reg_sel_e'(wr_addr))
            SEL_CTL:  ctl_q  <= wr_data;
            SEL_MODE: mode_q <= wr_data[0];
            SEL_GATE: gate_q <= wr_data;
            default:  ;
         endcase
      end
   end

   always_comb begin
      unique case (reg_sel_e'(rd_addr))
         SEL_CTL:  rd_data = ctl_q;
         SEL_MODE: rd_data = {{(REG_W-1){1'b0}}, mode_q};
         SEL_GATE: rd_data = gate_q;
         default:  rd_data = '0;
      endcase
   end

   assign ctl_en   = ctl_q[EN_BIT];
   assign ctl_code = ctl_q[CODE_W-1:0];
   assign mode_div = mode_q;
   assign gate_ok  = (gate_q == GATE_RUN);

endmodule

// File: rtl/sdclk_ratio_dec.sv
module sdclk_ratio_dec #(
   parameter int unsigned CODE_W     = 7,
   parameter int unsigned BASE_SHIFT = 3,
   parameter int unsigned ZERO_SHIFT = 2,
   parameter int unsigned SH_W       = 4
) (
   input  logic [CODE_W-1:0] code,
   output logic [SH_W-1:0]   half_sh
);

   // half-period exponent: ratio 2^s has half period 2^(s-1)
   logic [SH_W-1:0] pick [CODE_W+1];

   assign pick[CODE_W] = SH_W'(ZERO_SHIFT - 1);

   // lower code bits override higher ones: lowest set bit wins
   for (genvar i = 0; i < CODE_W; i++) begin : g_pri
      assign pick[i] = code[i] ? SH_W'(BASE_SHIFT - 1 + i) : pick[i+1];
   end

   assign half_sh = pick[0];

endmodule

// File: rtl/sdclk_divgen.sv
module sdclk_divgen #(
   parameter int unsigned SH_W      = 4,
   parameter int unsigned CNT_W     = 8,
   parameter bit          DIRECT_EN = 1'b1,
   parameter int unsigned RST_SH    = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            want_run,
   input  logic            want_direct,
   input  logic [SH_W-1:0] want_sh,
   output logic            div_clk,
   output logic            act_run,
   output logic            act_direct,
   output logic [SH_W-1:0] act_sh,
   output logic            card_clk
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   half_len;
   logic [CNT_W-1:0] term;
   logic             div_q;
   logic             run_q;
   logic             dir_q;
   logic [SH_W-1:0]  sh_q;

   assign half_len = (CNT_W+1)'(1) << sh_q;
   assign term     = CNT_W'(half_len - 1'b1);

   // a new setting is adopted only when a low phase ends
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         div_q <= 1'b0;
         run_q <= 1'b0;
         dir_q <= 1'b0;
         sh_q  <= SH_W'(RST_SH);
      end else if (cnt_q == term) begin
         cnt_q <= '0;
         if (div_q) begin
            div_q <= 1'b0;
         end else begin
            run_q <= want_run;
            dir_q <= want_direct;
            sh_q  <= want_sh;
            div_q <= want_run & ~want_direct;
         end
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   if (DIRECT_EN) begin : g_direct
      logic gate_q;
      // refreshed while the host clock is low, so the AND never chops a pulse
      always_ff @(negedge clk or negedge rst_n) begin
         if (!rst_n) gate_q <= 1'b0;
         else        gate_q <= run_q & dir_q;
      end
      assign card_clk = dir_q ? (clk & gate_q) : div_q;
   end else begin : g_divided_only
      assign card_clk = div_q;
   end

   assign div_clk    = div_q;
   assign act_run    = run_q;
   assign act_direct = dir_q;
   assign act_sh     = sh_q;

endmodule

// File: rtl/sdclk_ctrl.sv
module sdclk_ctrl
   import sdclk_pkg::*;
#(
   parameter int unsigned CODE_W     = 7,
   parameter int unsigned BASE_SHIFT = 3,
   parameter int unsigned ZERO_SHIFT = 2,
   parameter bit          DIRECT_EN  = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [1:0]  wr_addr,
   input  logic [15:0] wr_data,
   input  logic [1:0]  rd_addr,
   output logic [15:0] rd_data,
   output logic        card_clk,
   output logic        busy
);

   localparam int unsigned REG_W    = 16;
   localparam int unsigned MAX_HSH  = BASE_SHIFT + CODE_W - 2;
   localparam int unsigned CNT_W    = MAX_HSH;
   localparam int unsigned SH_W     = $clog2(MAX_HSH + 1);
   localparam int unsigned BUSY_MAX = 2 << MAX_HSH;

   if (CODE_W < 1 || CODE_W > 8) begin : g_bad_code_w
      $error("CODE_W must lie in 1..8 to fit the low byte");
   end
   if (BASE_SHIFT < 2) begin : g_bad_base
      $error("BASE_SHIFT must be at least 2");
   end
   if (ZERO_SHIFT < 1 || ZERO_SHIFT > MAX_HSH + 1) begin : g_bad_zero
      $error("ZERO_SHIFT out of range");
   end
   if (CODE_W > EN_BIT) begin : g_bad_overlap
      $error("ratio code overlaps the enable bit");
   end

   logic              ctl_en;
   logic [CODE_W-1:0] ctl_code;
   logic              mode_div;
   logic              gate_ok;
   logic [SH_W-1:0]   want_sh;
   logic              want_run;
   logic              want_direct;
   logic              div_clk;
   logic              act_run;
   logic              act_direct;
   logic [SH_W-1:0]   act_sh;

   sdclk_regs #(
      .REG_W  (REG_W),
      .CODE_W (CODE_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .ctl_en   (ctl_en),
      .ctl_code (ctl_code),
      .mode_div (mode_div),
      .gate_ok  (gate_ok)
   );

   sdclk_ratio_dec #(
      .CODE_W     (CODE_W),
      .BASE_SHIFT (BASE_SHIFT),
      .ZERO_SHIFT (ZERO_SHIFT),
      .SH_W       (SH_W)
   ) u_dec (
      .code    (ctl_code),
      .half_sh (want_sh)
   );

   assign want_run = ctl_en & gate_ok;

   if (DIRECT_EN) begin : g_mode
      assign want_direct = ~mode_div;
   end else begin : g_no_mode
      logic unused_mode;
      assign unused_mode = mode_div;
      assign want_direct = 1'b0;
   end

   sdclk_divgen #(
      .SH_W      (SH_W),
      .CNT_W     (CNT_W),
      .DIRECT_EN (DIRECT_EN),
      .RST_SH    (MAX_HSH)
   ) u_gen (
      .clk         (clk),
      .rst_n       (rst_n),
      .want_run    (want_run),
      .want_direct (want_direct),
      .want_sh     (want_sh),
      .div_clk     (div_clk),
      .act_run     (act_run),
      .act_direct  (act_direct),
      .act_sh      (act_sh),
      .card_clk    (card_clk)
   );

   assign busy = (want_run != act_run) | (want_direct != act_direct) | (want_sh != act_sh);

endmodule

// File: rtl/sdclk_ctrl_chk.sv
module sdclk_ctrl_chk #(
   parameter int unsigned SH_W     = 4,
   parameter int unsigned BUSY_MAX = 512
) (
   input logic            clk,
   input logic            rst_n,
   input logic            card_clk,
   input logic            busy,
   input logic            div_clk,
   input logic            act_run,
   input logic            act_direct,
   input logic [SH_W-1:0] act_sh
);

   logic            div_d;
   logic [31:0]     ph_len;
   logic [SH_W-1:0] sh_d;
   logic [31:0]     busy_len;
   logic [SH_W+1:0] act_all;

   assign act_all = {act_run, act_direct, act_sh};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_d    <= 1'b0;
         ph_len   <= '0;
         sh_d     <= '0;
         busy_len <= '0;
      end else begin
         div_d    <= div_clk;
         ph_len   <= (div_clk != div_d) ? 32'd1 : ph_len + 32'd1;
         sh_d     <= act_sh;
         busy_len <= busy ? busy_len + 32'd1 : 32'd0;
      end
   end

   // R1
   reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!div_clk && !busy && !card_clk));

   // R7
   high_phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (div_d && !div_clk) |-> (ph_len == (32'd1 << sh_d)));

   // R7
   adopt_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_all != $past(act_all)) |-> !$past(div_clk));

   // R6
   rise_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(div_clk) |-> act_run);

   // R9
   direct_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act_direct |-> !div_clk);

   // R8
   busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_len <= BUSY_MAX);

endmodule

bind sdclk_ctrl sdclk_ctrl_chk #(
   .SH_W     (SH_W),
   .BUSY_MAX (BUSY_MAX)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .card_clk   (card_clk),
   .busy       (busy),
   .div_clk    (div_clk),
   .act_run    (act_run),
   .act_direct (act_direct),
   .act_sh     (act_sh)
);

// File: tb/sim_sdclk_ctrl.sv
module sim_sdclk_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   logic        clk;
   logic        rst_n;
   logic        wr_en;
   logic [1:0]  wr_addr;
   logic [15:0] wr_data;
   logic [1:0]  rd_addr;
   logic [15:0] rd_data;
   logic        card_clk;
   logic        busy;

   int checks   = 0;
   int failures = 0;
   bit done     = 0;

   typedef struct {
      int    half;
      string tag;
   } exp_t;

   exp_t exp_q[$];

   bit mon_on = 0;
   bit armed  = 0;
   bit prev_s = 0;
   int hi_cnt = 0;
   int lo_cnt = 0;
   int hi_run = 0;
   int last_hi = 0;

   sdclk_ctrl u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .card_clk (card_clk),
      .busy     (busy)
   );

   initial begin
      clk = 1'b0;
      forever #(CLK_PERIOD/2) clk = ~clk;
   end

   // monitor: samples mid-cycle, measures whole periods rise to rise
   always @(negedge clk) begin
      exp_t item;
      bit cur;
      cur = card_clk;
      if (cur) hi_run++;
      else begin
         if (prev_s) last_hi = hi_run;
         hi_run = 0;
      end
      if (!mon_on) armed = 0;
      else begin
         if (cur && !prev_s) begin
            if (armed && exp_q.size() > 0) begin
               item = exp_q.pop_front();
               checks++;
               if (hi_cnt != item.half || lo_cnt != item.half) begin
                  failures++;
                  $display("FAIL %s period: actual hi=%0d lo=%0d expected hi=%0d lo=%0d",
                           item.tag, hi_cnt, lo_cnt, item.half, item.half);
               end
            end
            armed  = 1;
            hi_cnt = 0;
            lo_cnt = 0;
         end
         if (armed) begin
            if (cur) hi_cnt++;
            else     lo_cnt++;
         end
      end
      prev_s = cur;
   end

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      end
   endtask

   initial begin
      #(CLK_PERIOD * WATCHDOG);
      failures++;
      $display("FAIL all watchdog: actual=expired expected=finish before %0d cycles", WATCHDOG);
      summary();
      $finish;
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      wr_addr = a;
      wr_data = d;
      wr_en   = 1'b1;
      tick();
      wr_en   = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [1:0] a, input int exp);
      rd_addr = a;
      #1;
      chk(req, "readback", int'(rd_data), exp);
   endtask

   task automatic wait_idle(input string req, output int took);
      took = 0;
      while (busy && took < 2000) begin
         tick();
         took++;
      end
      if (took >= 2000) chk(req, "busy never cleared", 1, 0);
   endtask

   task automatic expect_periods(input int half, input int n, input string req);
      int took;
      wait_idle(req, took);
      mon_on = 1;
      for (int i = 0; i < n; i++) begin
         exp_t e;
         e.half = half;
         e.tag  = req;
         exp_q.push_back(e);
      end
      while (exp_q.size() > 0) tick();
      mon_on = 0;
   endtask

   task automatic expect_low(input int n, input string req);
      int highs = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (card_clk) highs++;
      end
      #1;
      chk(req, "high samples while stopped", highs, 0);
   endtask

   initial begin
      int took;
      rst_n   = 1'b0;
      wr_en   = 1'b0;
      wr_addr = '0;
      wr_data = '0;
      rd_addr = '0;
      repeat (4) tick();
      rst_n = 1'b1;
      tick();

      // R1 reset state
      chk("R1", "card_clk", int'(card_clk), 0);
      chk("R1", "busy", int'(busy), 0);
      rd_chk("R1", 2'd0, 'h0040);
      rd_chk("R1", 2'd1, 1);
      rd_chk("R1", 2'd2, 0);

      // R2 register map
      wr(2'd2, 16'h1234);
      rd_chk("R2", 2'd2, 'h1234);
      wr(2'd2, 16'h0000);
      wr(2'd0, 16'h8040);
      rd_chk("R2", 2'd0, 'h8040);
      wr(2'd1, 16'hfffe);
      rd_chk("R2", 2'd1, 0);
      wr(2'd1, 16'h0001);
      rd_chk("R2", 2'd1, 1);
      rd_chk("R2", 2'd3, 0);

      // start: enable first, then run-gate word
      wr(2'd0, 16'h0140);
      wr(2'd2, 16'h0100);
      expect_periods(256, 2, "R3");
      wr(2'd0, 16'h0101);
      expect_periods(4, 4, "R3");
      wr(2'd0, 16'h0108);
      expect_periods(32, 2, "R3");
      wr(2'd0, 16'h0104);
      expect_periods(16, 3, "R3");

      // R4 empty code and bit 7
      wr(2'd0, 16'h0100);
      expect_periods(2, 4, "R4");
      wr(2'd0, 16'h0180);
      expect_periods(2, 3, "R4");

      // R5 lowest set bit decides
      wr(2'd0, 16'h0106);
      expect_periods(8, 3, "R5");
      wr(2'd0, 16'h0150);
      expect_periods(64, 2, "R5");

      // R8 busy behaviour, old half period 4
      wr(2'd0, 16'h0101);
      expect_periods(4, 2, "R8");
      wr(2'd0, 16'h0102);
      chk("R8", "busy after change", int'(busy), 1);
      wait_idle("R8", took);
      chk("R8", "adoption within two old half periods", int'(took + 1 <= 8), 1);
      wr(2'd0, 16'h1102);
      chk("R8", "busy after no-effect write", int'(busy), 0);
      expect_periods(8, 2, "R8");

      // R6 wrong run-gate word stops the clock
      wr(2'd2, 16'h0101);
      wait_idle("R6", took);
      expect_low(64, "R6");
      wr(2'd2, 16'h0100);
      expect_periods(8, 2, "R6");

      // R7 stop requested just after a rising edge: high phase completes
      @(negedge clk);
      while (!card_clk) @(negedge clk);
      tick();
      wr(2'd0, 16'h0002);
      wait_idle("R7", took);
      @(negedge clk);
      #1;
      chk("R7", "last high phase length", last_hi, 8);

      // R10 code kept across stop, resumes at the same ratio
      expect_low(40, "R10");
      tick();
      rd_chk("R10", 2'd0, 'h0002);
      wr(2'd0, 16'h0102);
      expect_periods(8, 3, "R10");

      // R9 direct mode
      wr(2'd1, 16'h0000);
      wait_idle("R9", took);
      tick();
      for (int i = 0; i < 4; i++) begin
         @(posedge clk);
         #2;
         chk("R9", "direct high phase", int'(card_clk), 1);
         @(negedge clk);
         #2;
         chk("R9", "direct low phase", int'(card_clk), 0);
      end
      tick();
      wr(2'd0, 16'h0002);
      wait_idle("R9", took);
      tick();
      for (int i = 0; i < 3; i++) begin
         @(posedge clk);
         #2;
         chk("R9", "direct stopped", int'(card_clk), 0);
      end
      tick();
      wr(2'd1, 16'h0001);
      wr(2'd0, 16'h0101);
      expect_periods(4, 3, "R9");

      repeat (4) tick();
      summary();
      $finish;
   end

endmodule